// File: doc/BRIEF.md
# Column-Compression Tree Multiplier

This block multiplies two unsigned N-bit integers and returns the full 2N-bit product. N is a parameter and defaults to 8. It first builds the complete matrix of AND-gate partial-product bits. A bit formed from operand positions i and j has weight 2^(i+j), so it sits in column i+j.

The matrix is then squeezed in a series of stages that use only 3:2 full adders and 2:2 half adders. A full adder placed in column k leaves its sum in column k and sends its carry to column k+1 for the next stage. The stage height limits, from the last stage back to the first, run 2, 3, 4, 6, 9, 13, and so on: each limit is the previous one times three halves, rounded down. Each stage compresses a column only as far as needed to meet the next limit. Once no column holds more than two bits, a ripple-carry adder sums the two remaining rows. Its lowest position is a half adder because that position has no carry-in.

The tree is purely combinational. A parameter selects whether the product leaves the block directly or through one output register. That register has an asynchronous active-low clear.

Top module: `ccm_mul`

## Requirements
- R1: With OUT_REG=0, `product` equals a*b for every pair of unsigned operand values, with no clock edge needed.
- R2: With OUT_REG=1, `product` equals the a*b of the operands present at the most recent rising clock edge, so it is due one cycle after the operands are applied.
- R3: With OUT_REG=1, driving `rst_n` low sets `product` to zero at once, without waiting for a clock edge. It stays zero at every clock edge while `rst_n` remains low, whatever the operands are.
- R4: If either operand is zero, the product is zero.
- R5: With both operands at their largest value 2^N-1, the product is (2^N-1)^2, which for N=8 is 65025. All 2N output bits are used and nothing is lost.
- R6: Multiplying by one returns the other operand, zero-extended to 2N bits.
- R7: If one operand is the single-bit value 2^s, the product is the other operand shifted left by s positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier |
| product | output | 2N | Unsigned product a*b |

## Verification
The combinational variant has no register on its path, so its product is sampled a short settling delay after the operands change, before any clock edge can matter. The registered variant's product is due at the first rising edge after the operands are applied. The bench therefore changes operands on a falling edge and reads the registered result on the next falling edge, half a period after the capturing edge. In the exhaustive sweep, each falling edge checks the pair applied one cycle earlier before the bench drives the next pair. The reset checks read the product a moment after `rst_n` falls, to show that clearing does not wait for a clock, and again after an edge while reset is still held.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

    localparam int CCM_MAX_STAGES = 16;

    function automatic int ccm_limit(input int s);
        int d;
        d = 2;
        for (int i = 0; i < CCM_MAX_STAGES; i++) begin
            if (i < s) d = (d * 3) / 2;
        end
        return d;
    endfunction

    function automatic logic [1:0] ccm_fa(input logic x, input logic y, input logic z);
        return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
    endfunction

    function automatic logic [1:0] ccm_ha(input logic x, input logic y);
        return {x & y, x ^ y};
    endfunction

endpackage

// File: rtl/ccm_pp.sv
module ccm_pp #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [N*N-1:0] pp
);

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign pp[i*N+j] = a[i] & b[j];
        end
    end

endmodule

// File: rtl/ccm_reduce.sv
module ccm_reduce
    import ccm_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*N-1:0] pp,
    output logic [2*N-1:0] row_a,
    output logic [2*N-1:0] row_b
);

    localparam int W    = 2 * N;
    localparam int MAXH = N + 2;

    logic [MAXH-1:0] cur [W];
    logic [MAXH-1:0] nxt [W];
    int              h   [W];
    int              nh  [W];

    always_comb begin
        int       maxh;
        int       d;
        int       rem;
        int       idx;
        logic [1:0] cs;

        for (int k = 0; k < W; k++) begin
            cur[k] = '0;
            nxt[k] = '0;
            h[k]   = 0;
            nh[k]  = 0;
        end
        cs = '0;

        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                cur[i+j][h[i+j]] = pp[i*N+j];
                h[i+j] = h[i+j] + 1;
            end
        end

        maxh = N;
        for (int s = CCM_MAX_STAGES - 1; s >= 0; s--) begin
            d = ccm_limit(s);
            if (d < maxh) begin
                for (int k = 0; k < W; k++) begin
                    nxt[k] = '0;
                    nh[k]  = 0;
                end
                for (int k = 0; k < W; k++) begin
                    rem = h[k] + nh[k];
                    idx = 0;
                    for (int c = 0; c < N; c++) begin
                        if (rem > d) begin
                            if (rem - d >= 2) begin
                                cs  = ccm_fa(cur[k][idx], cur[k][idx+1], cur[k][idx+2]);
                                idx = idx + 3;
                                rem = rem - 2;
                            end else begin
                                cs  = ccm_ha(cur[k][idx], cur[k][idx+1]);
                                idx = idx + 2;
                                rem = rem - 1;
                            end
                            nxt[k][nh[k]] = cs[0];
                            nh[k] = nh[k] + 1;
                            if (k + 1 < W) begin
                                nxt[k+1][nh[k+1]] = cs[1];
                                nh[k+1] = nh[k+1] + 1;
                            end
                        end
                    end
                    for (int c = 0; c < MAXH; c++) begin
                        if (c >= idx && c < h[k]) begin
                            nxt[k][nh[k]] = cur[k][c];
                            nh[k] = nh[k] + 1;
                        end
                    end
                end
                for (int k = 0; k < W; k++) begin
                    cur[k] = nxt[k];
                    h[k]   = nh[k];
                end
                maxh = d;
            end
        end

        for (int k = 0; k < W; k++) begin
            row_a[k] = cur[k][0];
            row_b[k] = cur[k][1];
        end
    end

endmodule

// File: rtl/ccm_cpa.sv
module ccm_cpa
    import ccm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] sum
);

    logic [W:0] carry;

    assign carry[0] = 1'b0;

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == 0) begin : g_half
            assign {carry[1], sum[0]} = ccm_ha(x[0], y[0]);
        end else begin : g_full
            assign {carry[k+1], sum[k]} = ccm_fa(x[k], y[k], carry[k]);
        end
    end

endmodule

// File: rtl/ccm_mul.sv
module ccm_mul #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] product
);

    localparam int W = 2 * N;

    logic [N*N-1:0] pp;
    logic [W-1:0]   row_a;
    logic [W-1:0]   row_b;
    logic [W-1:0]   sum;

    ccm_pp #(.N(N)) u_pp (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    ccm_reduce #(.N(N)) u_reduce (
        .pp    (pp),
        .row_a (row_a),
        .row_b (row_b)
    );

    ccm_cpa #(.W(W)) u_cpa (
        .x   (row_a),
        .y   (row_b),
        .sum (sum)
    );

    if (OUT_REG) begin : g_reg
        logic [W-1:0] product_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) product_q <= '0;
            else        product_q <= sum;
        end
        assign product = product_q;
    end else begin : g_comb
        assign product = sum;
    end

endmodule

// File: rtl/ccm_mul_chk.sv
module ccm_mul_chk #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic [2*N-1:0] product
);

    localparam int W = 2 * N;

    if (OUT_REG) begin : g_reg_chk
        // R2
        a_r2_reg_product: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> product == W'($past(a)) * W'($past(b)));
        // R3
        a_r3_reset_clear: assert property (@(posedge clk)
            !rst_n |-> product == '0);
        // R4
        a_r4_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(a) == '0 || $past(b) == '0)) |-> product == '0);
    end else begin : g_comb_chk
        // R1
        a_r1_comb_product: assert property (@(posedge clk) disable iff (!rst_n)
            product == W'(a) * W'(b));
        // R4
        a_r4_zero_comb: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> product == '0);
        // R6
        a_r6_identity: assert property (@(posedge clk) disable iff (!rst_n)
            (b == N'(1)) |-> product == W'(a));
    end

endmodule

bind ccm_mul ccm_mul_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a       (a),
    .b       (b),
    .product (product)
);

// File: tb/ccm_mul_test.sv
`timescale 1ns/1ps
module ccm_mul_test;

    localparam int N = 8;
    localparam int W = 2 * N;

    // {a, b, expected product}
    localparam logic [31:0] VEC [8] = '{
        {8'd255, 8'd255, 16'd65025},
        {8'd0,   8'd200, 16'd0},
        {8'd1,   8'd173, 16'd173},
        {8'd128, 8'd3,   16'd384},
        {8'd16,  8'd16,  16'd256},
        {8'd170, 8'd85,  16'd14450},
        {8'd255, 8'd1,   16'd255},
        {8'd2,   8'd127, 16'd254}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic [W-1:0] p_reg;
    logic [W-1:0] p_comb;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    ccm_mul #(.N(N), .OUT_REG(1'b1)) uut (
        .clk (clk), .rst_n (rst_n), .a (a), .b (b), .product (p_reg)
    );

    ccm_mul #(.N(N), .OUT_REG(1'b0)) uut_comb (
        .clk (clk), .rst_n (rst_n), .a (a), .b (b), .product (p_comb)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_vec(input string tag, input logic [N-1:0] va,
                           input logic [N-1:0] vb, input logic [W-1:0] exp);
        @(negedge clk);
        a = va;
        b = vb;
        #1;
        chk({tag, " comb"}, p_comb, exp);
        @(negedge clk);
        chk({tag, " reg"}, p_reg, exp);
    endtask

    initial begin
        logic [W-1:0] prev_exp;
        bit           have_prev;

        // R3: reset state with nonzero operands present
        a = 8'd255;
        b = 8'd255;
        repeat (2) @(negedge clk);
        chk("R3 reset holds zero", p_reg, 16'd0);
        chk("R1 comb during reset", p_comb, 16'd65025);
        rst_n = 1'b1;

        // Table walk (R1, R2)
        for (int v = 0; v < 8; v++) begin
            run_vec("R2 table", VEC[v][31:24], VEC[v][23:16], VEC[v][15:0]);
        end

        // Directed corners
        run_vec("R4 zero a", 8'd0, 8'd255, 16'd0);
        run_vec("R4 zero b", 8'd201, 8'd0, 16'd0);
        run_vec("R5 max", 8'd255, 8'd255, 16'd65025);
        run_vec("R6 one times", 8'd1, 8'd99, 16'd99);
        run_vec("R6 times one", 8'd231, 8'd1, 16'd231);
        run_vec("R7 shift 7", 8'd128, 8'd255, 16'd32640);
        run_vec("R7 shift 3", 8'd77, 8'd8, 16'd616);

        // R3: asynchronous clear mid-run
        run_vec("R2 before reset", 8'd200, 8'd201, 16'd40200);
        #1;
        rst_n = 1'b0;
        #0.5;
        chk("R3 async clear", p_reg, 16'd0);
        @(negedge clk);
        chk("R3 held over edge", p_reg, 16'd0);
        rst_n = 1'b1;
        run_vec("R2 after reset", 8'd13, 8'd11, 16'd143);

        // Exhaustive sweep (R1 comb, R2 reg), one cycle latency
        have_prev = 1'b0;
        prev_exp  = '0;
        for (int ai = 0; ai < 256; ai++) begin
            for (int bi = 0; bi < 256; bi++) begin
                @(negedge clk);
                if (have_prev) begin
                    chk("R1 sweep", p_comb, prev_exp);
                    chk("R2 sweep", p_reg, prev_exp);
                end
                a = ai[N-1:0];
                b = bi[N-1:0];
                prev_exp  = W'(ai * bi);
                have_prev = 1'b1;
            end
        end
        @(negedge clk);
        chk("R1 sweep", p_comb, prev_exp);
        chk("R2 sweep", p_reg, prev_exp);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule